// File: doc/BRIEF.md
# Region-Based I/O Wait-State Generator

This block sits between a processor core and a small external I/O space of 2048 sixteen-bit locations. The core issues a single read or write request with an 11-bit I/O address. The block splits the space into four equal regions of 512 locations each, picks the region from the two most significant address bits, and stretches the external strobes by that region's programmed number of wait cycles, from 0 to 7. When the access is complete it returns a one-cycle done pulse to the core. For reads, it also returns the captured data.

The wait counts live in one configuration register that sits at data-memory address 0x3FFE. The register has four 3-bit fields. After reset every field is 7, so untouched regions run at the slowest timing. The wait count for an access is taken from the register when the request is accepted. A register update made while an access is running therefore only affects later accesses.

Top module: `iowait_gen`

## Requirements
- R1: While a strobe is active, io_addr[10:0] carries the address latched at acceptance and io_addr[13:11] is 0. When no access is active, io_addr is all zero.
- R2: The region is req_addr[10:9]. Region r takes its wait count N from configuration bits [3r+2:3r], so region 0 uses bits 2:0 and region 3 uses bits 11:9.
- R3: An access accepted at a clock edge drives io_sel from the next cycle for exactly 1+N cycles. io_rd (read, req_write=0) or io_wr (write, req_write=1) is driven alongside io_sel, and the two are never high together.
- R4: req_done is high for exactly one cycle, the last cycle of the strobe, and is low at all other times.
- R5: For a read, io_rdata is captured at the clock edge that closes the last strobe cycle. req_rdata shows the captured value from the next cycle and keeps it until the next read completes.
- R6: During a write, io_wdata carries the latched write data and io_wdata_oe is 1 for every strobe cycle. Outside a write strobe, io_wdata_oe is 0 and io_wdata is 0.
- R7: The configuration register responds only when cfg_addr equals 0x3FFE. At that address, cfg_wr loads the register and cfg_rdata returns its value without a clock delay. At any other address, writes are ignored and cfg_rdata is 0.
- R8: Configuration bits 15:12 always read as 0, and values written to those bits are discarded.
- R9: After reset, the configuration register reads 0x0FFF, which sets a wait count of 7 in every region.
- R10: The wait count is sampled at acceptance. A configuration write during an access, or at the same clock edge as acceptance, does not change that access's length.
- R11: req_ready is 1 only when no access is active. A request held on req_valid is accepted only after req_done has been issued, so back-to-back accesses with N=0 complete once every two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core requests an I/O access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 11 | I/O word address |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Block idle; a valid request is accepted at this edge |
| req_done | output | 1 | Final cycle of the access |
| req_rdata | output | 16 | Last captured read data |
| io_sel | output | 1 | I/O space select strobe |
| io_addr | output | 14 | External address, upper 3 bits forced to 0 |
| io_rd | output | 1 | Read strobe |
| io_wr | output | 1 | Write strobe |
| io_wdata | output | 16 | Data driven toward the I/O bus |
| io_wdata_oe | output | 1 | Output enable for io_wdata |
| io_rdata | input | 16 | Data returned from the I/O bus |
| cfg_wr | input | 1 | Configuration write enable |
| cfg_addr | input | 14 | Data-memory address of the configuration access |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Configuration read data |

## Verification
- **Strobe timing.** The strobe outputs and req_ready change one cycle after the accepting edge. req_done falls in the 1+N-th strobe cycle.
- **Read data.** req_rdata updates one cycle after req_done.
- **Configuration.** cfg_rdata follows cfg_addr in the same cycle. A configuration write is visible from the next cycle.
- **How the bench checks this.** A behavioural model advances at each rising edge. Every output is compared against it at the following falling edge, so each result is checked in the cycle it is due. Directed checks also count strobe cycles for each region and setting, including a configuration write made in the middle of an access and a request held high across accesses.

// File: rtl/iowait_pkg.sv
package iowait_pkg;
    localparam int IO_AW      = 11;      // I/O word address bits
    localparam int EXT_AW     = 14;      // external address bus width
    localparam int DW         = 16;      // data width
    localparam int WAIT_W     = 3;       // bits per region wait field
    localparam int N_REGION   = 4;       // equal-size regions
    localparam int CFG_AW     = 14;      // data-memory address width
    localparam logic [CFG_AW-1:0] CFG_LOC = 14'h3FFE;
endpackage

// File: rtl/iow_cfg_reg.sv
module iow_cfg_reg #(
    parameter int DATA_W  = 16,
    parameter int WS_W    = 3,
    parameter int NREG    = 4,
    parameter int CAW     = 14,
    parameter logic [CAW-1:0] CFG_ADDR = '1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic [CAW-1:0]       cfg_addr,
    input  logic [DATA_W-1:0]    cfg_wdata,
    output logic [DATA_W-1:0]    cfg_rdata,
    output logic [NREG*WS_W-1:0] fields
);
    localparam int USED = NREG * WS_W;

    logic [USED-1:0] fld_d, fld_q;
    logic            hit;

    assign hit = (cfg_addr == CFG_ADDR);

    always_comb begin
        fld_d = fld_q;
        if (cfg_wr && hit) begin
            fld_d = cfg_wdata[USED-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fld_q <= '1;
        end else begin
            fld_q <= fld_d;
        end
    end

    assign cfg_rdata = hit ? DATA_W'(fld_q) : '0;
    assign fields    = fld_q;

    generate
        if (DATA_W > USED) begin : g_rsvd
            logic unused_rsvd;
            assign unused_rsvd = ^cfg_wdata[DATA_W-1:USED];
        end
    endgenerate
endmodule

// File: rtl/iow_region_sel.sv
module iow_region_sel #(
    parameter int WS_W  = 3,
    parameter int NREG  = 4,
    localparam int SEL_W = $clog2(NREG)
) (
    input  logic [SEL_W-1:0]     region,
    input  logic [NREG*WS_W-1:0] fields,
    output logic [WS_W-1:0]      wait_cnt
);
    logic [WS_W-1:0] tbl [NREG];

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_slice
            assign tbl[g] = fields[g*WS_W +: WS_W];
        end
    endgenerate

    assign wait_cnt = tbl[region];
endmodule

// File: rtl/iow_access_fsm.sv
module iow_access_fsm #(
    parameter int ADDR_W = 11,
    parameter int EXT_W  = 14,
    parameter int DATA_W = 16,
    parameter int WS_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [WS_W-1:0]   wait_cnt,
    output logic              req_ready,
    output logic              req_done,
    output logic [DATA_W-1:0] req_rdata,
    output logic              io_sel,
    output logic [EXT_W-1:0]  io_addr,
    output logic              io_rd,
    output logic              io_wr,
    output logic [DATA_W-1:0] io_wdata,
    output logic              io_wdata_oe,
    input  logic [DATA_W-1:0] io_rdata
);
    typedef struct packed {
        logic              busy;
        logic              wr;
        logic [WS_W-1:0]   left;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
    } acc_t;

    acc_t st_d, st_q;
    logic last;

    assign last = st_q.busy && (st_q.left == '0);

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            if (last) begin
                st_d.busy = 1'b0;
                if (!st_q.wr) begin
                    st_d.rdata = io_rdata;
                end
            end else begin
                st_d.left = st_q.left - 1'b1;
            end
        end else if (req_valid) begin
            st_d.busy  = 1'b1;
            st_d.wr    = req_write;
            st_d.left  = wait_cnt;
            st_d.addr  = req_addr;
            st_d.wdata = req_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready   = !st_q.busy;
    assign req_done    = last;
    assign req_rdata   = st_q.rdata;
    assign io_sel      = st_q.busy;
    assign io_addr     = st_q.busy ? EXT_W'(st_q.addr) : '0;
    assign io_rd       = st_q.busy && !st_q.wr;
    assign io_wr       = st_q.busy && st_q.wr;
    assign io_wdata_oe = st_q.busy && st_q.wr;
    assign io_wdata    = (st_q.busy && st_q.wr) ? st_q.wdata : '0;
endmodule

// File: rtl/iowait_gen.sv
module iowait_gen
    import iowait_pkg::*;
#(
    parameter int ADDR_W = IO_AW,
    parameter int EXT_W  = EXT_AW,
    parameter int DATA_W = DW,
    parameter int WS_W   = WAIT_W,
    parameter int NREG   = N_REGION,
    parameter int CAW    = CFG_AW,
    parameter logic [CAW-1:0] CFG_ADDR = CFG_LOC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              req_done,
    output logic [DATA_W-1:0] req_rdata,
    output logic              io_sel,
    output logic [EXT_W-1:0]  io_addr,
    output logic              io_rd,
    output logic              io_wr,
    output logic [DATA_W-1:0] io_wdata,
    output logic              io_wdata_oe,
    input  logic [DATA_W-1:0] io_rdata,
    input  logic              cfg_wr,
    input  logic [CAW-1:0]    cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata
);
    localparam int SEL_W = $clog2(NREG);

    logic [NREG*WS_W-1:0] fields;
    logic [WS_W-1:0]      wait_cnt;

    iow_cfg_reg #(
        .DATA_W(DATA_W), .WS_W(WS_W), .NREG(NREG), .CAW(CAW), .CFG_ADDR(CFG_ADDR)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .fields(fields)
    );

    iow_region_sel #(
        .WS_W(WS_W), .NREG(NREG)
    ) u_sel (
        .region(req_addr[ADDR_W-1 -: SEL_W]), .fields(fields), .wait_cnt(wait_cnt)
    );

    iow_access_fsm #(
        .ADDR_W(ADDR_W), .EXT_W(EXT_W), .DATA_W(DATA_W), .WS_W(WS_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .wait_cnt(wait_cnt),
        .req_ready(req_ready), .req_done(req_done), .req_rdata(req_rdata),
        .io_sel(io_sel), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
        .io_wdata(io_wdata), .io_wdata_oe(io_wdata_oe), .io_rdata(io_rdata)
    );
endmodule

// File: rtl/iowait_gen_chk.sv
module iowait_gen_chk #(
    parameter int EXT_W  = 14,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              req_done,
    input logic              io_sel,
    input logic [EXT_W-1:0]  io_addr,
    input logic              io_rd,
    input logic              io_wr,
    input logic [DATA_W-1:0] io_wdata,
    input logic              io_wdata_oe,
    input logic [DATA_W-1:0] cfg_rdata
);
    // R1
    addr_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_addr[EXT_W-1:ADDR_W] == '0);

    // R1
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_sel && !req_done) |=> (io_sel && $stable(io_addr)));

    // R3
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_rd && io_wr));

    // R3
    strobe_in_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd || io_wr) |-> io_sel);

    // R4
    done_in_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |-> io_sel);

    // R4
    done_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |=> (!io_sel && !req_done));

    // R6
    wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && !req_done) |=> (io_wr && io_wdata_oe && $stable(io_wdata)));

    // R8
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[DATA_W-1:12] == '0);

    // R11
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_sel |-> !req_ready);
endmodule

bind iowait_gen iowait_gen_chk #(
    .EXT_W(EXT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .req_done(req_done),
    .io_sel(io_sel), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_wdata_oe(io_wdata_oe), .cfg_rdata(cfg_rdata)
);

// File: tb/iowait_gen_test.sv
`timescale 1ns/1ps
module iowait_gen_test;
    localparam logic [13:0] CFG_A = 14'h3FFE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [10:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, req_done;
    logic [15:0] req_rdata;
    logic        io_sel, io_rd, io_wr, io_wdata_oe;
    logic [13:0] io_addr;
    logic [15:0] io_wdata;
    logic [15:0] io_rdata = '0;
    logic        cfg_wr = 1'b0;
    logic [13:0] cfg_addr = CFG_A;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;

    integer errors = 0, checks = 0, cyc = 0;
    bit     finished = 1'b0;

    always #2.5 clk = ~clk;

    iowait_gen uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .req_done(req_done), .req_rdata(req_rdata), .io_sel(io_sel),
        .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata),
        .io_wdata_oe(io_wdata_oe), .io_rdata(io_rdata), .cfg_wr(cfg_wr),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
    );

    // behavioural reference model
    bit          m_busy = 0, m_wr = 0;
    integer      m_left = 0;
    logic [10:0] m_addr = '0;
    logic [15:0] m_wdata = '0, m_rdata = '0;
    logic [15:0] m_cfg = 16'h0FFF;

    always @(posedge clk) begin
        logic [15:0] old_cfg;
        if (!rst_n) begin
            m_busy = 0; m_wr = 0; m_left = 0; m_addr = '0;
            m_wdata = '0; m_rdata = '0; m_cfg = 16'h0FFF;
        end else begin
            old_cfg = m_cfg;
            if (cfg_wr && cfg_addr == CFG_A) m_cfg = cfg_wdata & 16'h0FFF;
            if (m_busy) begin
                if (m_left == 0) begin
                    m_busy = 0;
                    if (!m_wr) m_rdata = io_rdata;
                end else begin
                    m_left = m_left - 1;
                end
            end else if (req_valid) begin
                m_busy  = 1;
                m_wr    = req_write;
                m_left  = (old_cfg >> (3 * req_addr[10:9])) & 7;
                m_addr  = req_addr;
                m_wdata = req_wdata;
            end
        end
    end

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", r, cyc, act, exp);
        end
    endtask

    task automatic compare();
        bit ew;
        ew = m_busy && m_wr;
        chk("R11 req_ready", 32'(req_ready), 32'(!m_busy));
        chk("R3 io_sel", 32'(io_sel), 32'(m_busy));
        chk("R3 io_rd", 32'(io_rd), 32'(m_busy && !m_wr));
        chk("R3 io_wr", 32'(io_wr), 32'(ew));
        chk("R4 req_done", 32'(req_done), 32'(m_busy && m_left == 0));
        chk("R1 io_addr", 32'(io_addr), m_busy ? 32'(m_addr) : 32'd0);
        chk("R6 io_wdata_oe", 32'(io_wdata_oe), 32'(ew));
        chk("R6 io_wdata", 32'(io_wdata), ew ? 32'(m_wdata) : 32'd0);
        chk("R5 req_rdata", 32'(req_rdata), 32'(m_rdata));
        chk("R7 cfg_rdata", 32'(cfg_rdata), (cfg_addr == CFG_A) ? 32'(m_cfg) : 32'd0);
    endtask

    task automatic step();
        @(negedge clk);
        if (rst_n) compare();
        cyc++;
        io_rdata = 16'(cyc * 16'h1357 + 16'h0A5C);
    endtask

    task automatic cfg_write(input logic [13:0] a, input logic [15:0] v);
        cfg_wr = 1; cfg_addr = a; cfg_wdata = v;
        step();
        cfg_wr = 0; cfg_addr = CFG_A;
    endtask

    // one access; counts strobe cycles; optional config write in strobe cycle 2
    task automatic access(input bit wr, input logic [10:0] a, input logic [15:0] d,
                          input integer exp_len, input bit mid_cfg, input string r);
        integer n;
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
        step();
        req_valid = 0;
        n = 0;
        while (io_sel && n < 20) begin
            n++;
            if (mid_cfg && n == 2) begin cfg_wr = 1; cfg_wdata = 16'h0000; end
            else cfg_wr = 0;
            step();
        end
        cfg_wr = 0;
        chk(r, 32'(n), 32'(exp_len));
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1;
        step();
        // R9 reset value
        chk("R9 reset cfg", 32'(cfg_rdata), 32'h0FFF);
        chk("R11 idle ready after reset", 32'(req_ready), 32'd1);

        // R2/R3 reset timing: every region 1+7 cycles
        access(0, 11'h000, 16'h0, 8, 0, "R3 len region0 rst");
        access(1, 11'h3A5, 16'hBEEF, 8, 0, "R3 len region1 rst");
        access(0, 11'h5FF, 16'h0, 8, 0, "R3 len region2 rst");
        access(1, 11'h600, 16'h1234, 8, 0, "R3 len region3 rst");

        // R8 reserved bits
        cfg_write(CFG_A, 16'hFFFF);
        step();
        chk("R8 reserved read zero", 32'(cfg_rdata), 32'h0FFF);

        // R2 distinct fields: r0=0 r1=1 r2=3 r3=6 -> 0x0CC8
        cfg_write(CFG_A, 16'hF000 | 16'h0CC8);
        step();
        chk("R2 cfg readback", 32'(cfg_rdata), 32'h0CC8);
        access(0, 11'h1FF, 16'h0, 1, 0, "R2 region0 N=0");
        access(1, 11'h200, 16'hA5A5, 2, 0, "R2 region1 N=1");
        access(0, 11'h4C3, 16'h0, 4, 0, "R2 region2 N=3");
        access(1, 11'h7FF, 16'h5A5A, 7, 0, "R2 region3 N=6");
        access(0, 11'h7AB, 16'h0, 7, 0, "R5 read region3");

        // R7 other address ignored and reads zero
        cfg_write(14'h3FFD, 16'h0000);
        cfg_addr = 14'h3FFD;
        step();
        chk("R7 other addr reads zero", 32'(cfg_rdata), 32'h0);
        cfg_addr = CFG_A;
        step();
        chk("R7 write elsewhere ignored", 32'(cfg_rdata), 32'h0CC8);

        // R10 write zero mid-access, length unchanged; next access uses new value
        access(0, 11'h700, 16'h0, 7, 1, "R10 mid-access cfg write");
        chk("R10 cfg updated", 32'(cfg_rdata), 32'h0);
        access(1, 11'h701, 16'h7777, 1, 0, "R10 new value next access");

        // R10 config write at the acceptance edge
        cfg_wdata = 16'h0E00; cfg_wr = 1;
        access(0, 11'h650, 16'h0, 1, 0, "R10 write at accept edge");
        step();
        chk("R10 cfg after accept-edge write", 32'(cfg_rdata), 32'h0E00);
        cfg_write(CFG_A, 16'h0000);

        // R11 held request: N=0 accesses complete every 2 cycles
        begin
            integer dn;
            dn = 0;
            req_valid = 1; req_write = 0; req_addr = 11'h010;
            step();
            for (int i = 0; i < 10; i++) begin
                if (req_done) dn++;
                step();
            end
            req_valid = 0;
            chk("R11 back-to-back done count", 32'(dn), 32'd5);
        end
        repeat (4) step();

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog R11: actual=hung expected=complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule